// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

This block is a synthesizable behavioural model of a small boot-block flash device. A byte-addressed array is divided into five blocks that can each be erased on their own. There is one boot block, two parameter blocks next to it, and two main blocks of different sizes. Block sizes are counted in units of `UNIT_BYTES`. Relative to each other they stay 2 : 1 : 1 : 12 : 16 units. With `UNIT_BYTES = 8192` the array is the full 256 KiB. The default is a much smaller unit, so that the model stays cheap to elaborate. The `BOOT_TOP` parameter places the boot block and the parameter blocks at the high end of the map instead of the low end.

A host writes single-cycle commands on a byte lane. Program and erase each take a two-write sequence. An internal write engine then stays busy for a number of clock cycles set by a parameter. When it finishes, it commits the change, verifies the result and updates a status byte with sticky error flags. The boot block is locked while the write-protect pin is low. The active-low reset pin cancels any running operation, clears the command and status state, blocks writes and blanks the data output. Reads are 16-bit words, or single bytes with one extra low address bit.

Top module: `bbf_flash`

## Requirements
- R1: After `rst_n` is released, the device is in read-array mode and the status byte reads 0x80. The array contents are kept across reset.
- R2: Writing 0x40 and then data at an address programs one word (`byte_n`=1, the even/odd byte pair; data[7:0] goes to the even byte) or one byte (`byte_n`=0, data[7:0]). Programming can only clear bits. The engine stays busy for exactly `PROG_CYC` cycles after the data write.
- R3: If the stored value after programming differs from the requested value, status bit 4 is set. The stored value becomes old AND new.
- R4: Writing 0x20 and then 0xD0 at any address in a block sets every byte of that block to 0xFF. The engine stays busy for exactly `ERASE_CYC` cycles.
- R5: If the second erase write is anything other than 0xD0, status bits 5 and 4 are set at once. No operation starts and the array is unchanged.
- R6: While `wp_n` is 0, a program or erase aimed at the boot block still runs its busy time. It then leaves the array unchanged and sets bit 1 together with bit 4 (program) or bit 5 (erase). Other blocks are unaffected by `wp_n`.
- R7: With `BOOT_TOP`=0, the block map in units is: boot 0–1, parameter 2, parameter 3, main 4–15, main 16–31. `BOOT_TOP`=1 mirrors the map. An erase never changes bytes outside the addressed block.
- R8: While busy, `dout` shows the status byte with bit 7 = 0, and every write is ignored.
- R9: Error bits 5, 4 and 1 stay set until a 0x50 command clears them.
- R10: While `rp_n` is 0, `dout` is 0 and writes are ignored. The cycle that samples it low aborts any operation with the array unchanged, clears the status errors and selects read-array mode.
- R11: In read-array mode, `byte_n`=0 gives {0x00, byte at `addr`}. `byte_n`=1 gives {odd byte, even byte} of the pair at `addr`.
- R12: Command 0xFF selects read-array mode and 0x70 selects status mode, in which `dout` = {0x00, status}. After any program or erase sequence, the device shows status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rp_n | input | 1 | Active-low reset / deep power-down pin |
| wp_n | input | 1 | Active-low boot-block write protect |
| byte_n | input | 1 | 0 = byte access, 1 = word access |
| we | input | 1 | One-cycle bus write strobe |
| addr | input | AW (UNIT_LG+5) | Byte address |
| din | input | 16 | Write data; commands use bits 7:0 |
| dout | output | 16 | Read data or status |

## Verification
`dout` is combinational from state, so a mode change or status update caused by a write sampled at one rising edge can be seen at the following falling edge. The bench drives every input on a falling edge and samples one time step later. After the edge that takes the data or confirm write, the ready bit stays low for exactly `PROG_CYC` or `ERASE_CYC` falling edges. The bench counts those edges and compares the count with the parameter. Error flags appear in the same cycle the ready bit returns. A sequence error or a power-down blanking shows at the first falling edge after the write or pin change.

// File: rtl/bbf_pkg.sv
package bbf_pkg;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_PROG  = 2'd1,
    CS_ERASE = 2'd2
  } cui_st_t;

  localparam logic [7:0] CMD_READ  = 8'hFF;
  localparam logic [7:0] CMD_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLR   = 8'h50;
  localparam logic [7:0] CMD_PROG  = 8'h40;
  localparam logic [7:0] CMD_ERASE = 8'h20;
  localparam logic [7:0] CMD_CONF  = 8'hD0;

  localparam int UNIT_BITS = 5;   // 32 map units

  // Block index: 0 boot, 1/2 parameter, 3 small main, 4 large main
  function automatic logic [2:0] unit_to_blk(input logic [4:0] u, input logic top);
    logic [4:0] m;
    m = top ? (5'd31 - u) : u;
    if (m < 5'd2)       return 3'd0;
    else if (m == 5'd2) return 3'd1;
    else if (m == 5'd3) return 3'd2;
    else if (m < 5'd16) return 3'd3;
    else                return 3'd4;
  endfunction

endpackage

// File: rtl/bbf_blkmap.sv
module bbf_blkmap
  import bbf_pkg::*;
#(
  parameter int AW       = 9,
  parameter bit BOOT_TOP = 1'b0
) (
  input  logic [AW-1:0] addr,
  output logic [2:0]    blk,
  output logic          is_boot
);
  logic [UNIT_BITS-1:0] unit;

  always_comb begin
    unit    = addr[AW-1 -: UNIT_BITS];
    blk     = unit_to_blk(unit, BOOT_TOP);
    is_boot = (blk == 3'd0);
  end
endmodule

// File: rtl/bbf_array.sv
module bbf_array
  import bbf_pkg::*;
#(
  parameter int AW       = 9,
  parameter bit BOOT_TOP = 1'b0
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic                wr_byte,
  input  logic [15:0]         wr_data,
  input  logic                er_en,
  input  logic [2:0]          er_blk,
  input  logic [1:0][AW-1:0]  rd_addr,
  input  logic [1:0]          rd_byte,
  output logic [1:0][15:0]    rd_data
);
  localparam int DEPTH   = 1 << AW;
  localparam int UNIT_LG = AW - UNIT_BITS;

  logic [7:0] mem [DEPTH];

  // Nonvolatile storage: deliberately not reset
  always_ff @(posedge clk) begin
    if (er_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (unit_to_blk(UNIT_BITS'(i >> UNIT_LG), BOOT_TOP) == er_blk)
          mem[i] <= 8'hFF;
      end
    end else if (wr_en) begin
      if (wr_byte) begin
        mem[wr_addr] <= wr_data[7:0];
      end else begin
        mem[{wr_addr[AW-1:1], 1'b0}] <= wr_data[7:0];
        mem[{wr_addr[AW-1:1], 1'b1}] <= wr_data[15:8];
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    always_comb begin
      if (rd_byte[p])
        rd_data[p] = {8'h00, mem[rd_addr[p]]};
      else
        rd_data[p] = {mem[{rd_addr[p][AW-1:1], 1'b1}], mem[{rd_addr[p][AW-1:1], 1'b0}]};
    end
  end
endmodule

// File: rtl/bbf_wsm.sv
module bbf_wsm
  import bbf_pkg::*;
#(
  parameter int AW        = 9,
  parameter bit BOOT_TOP  = 1'b0,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rp_n,
  input  logic          wp_n,
  input  logic          start_prog,
  input  logic          start_erase,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_data,
  input  logic          req_byte,
  input  logic [15:0]   old_data,
  output logic          busy,
  output logic [AW-1:0] op_addr,
  output logic          op_byte,
  output logic [15:0]   commit_data,
  output logic [2:0]    commit_blk,
  output logic          commit_prog,
  output logic          commit_erase,
  output logic          done,
  output logic          fail_prog,
  output logic          fail_erase,
  output logic          fail_lock
);
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          busy_q, busy_d;
  logic          kind_q, kind_d;   // 1 = erase
  logic [AW-1:0] addr_q, addr_d;
  logic [15:0]   data_q, data_d;
  logic          byte_q, byte_d;
  logic [CW-1:0] cnt_q,  cnt_d;
  logic          is_boot, locked, mismatch;
  logic [15:0]   merged;

  bbf_blkmap #(.AW(AW), .BOOT_TOP(BOOT_TOP)) u_map (
    .addr(addr_q), .blk(commit_blk), .is_boot(is_boot)
  );

  always_comb begin
    busy_d = busy_q;
    kind_d = kind_q;
    addr_d = addr_q;
    data_d = data_q;
    byte_d = byte_q;
    cnt_d  = cnt_q;
    done   = 1'b0;
    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done   = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (start_prog) begin
      busy_d = 1'b1;
      kind_d = 1'b0;
      addr_d = req_addr;
      data_d = req_data;
      byte_d = req_byte;
      cnt_d  = CW'(PROG_CYC - 1);
    end else if (start_erase) begin
      busy_d = 1'b1;
      kind_d = 1'b1;
      addr_d = req_addr;
      byte_d = 1'b0;
      cnt_d  = CW'(ERASE_CYC - 1);
    end
    if (!rp_n) begin
      busy_d = 1'b0;
      done   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      byte_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      kind_q <= kind_d;
      addr_q <= addr_d;
      data_q <= data_d;
      byte_q <= byte_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    locked       = is_boot && !wp_n;
    merged       = old_data & data_q;
    mismatch     = byte_q ? (merged[7:0] != data_q[7:0]) : (merged != data_q);
    commit_data  = merged;
    commit_prog  = done && !kind_q && !locked;
    commit_erase = done &&  kind_q && !locked;
    fail_prog    = done && !kind_q && (locked || mismatch);
    fail_erase   = done &&  kind_q && locked;
    fail_lock    = done && locked;
    busy         = busy_q;
    op_addr      = addr_q;
    op_byte      = byte_q;
  end
endmodule

// File: rtl/bbf_cui.sv
module bbf_cui
  import bbf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rp_n,
  input  logic       we,
  input  logic [7:0] cmd,
  input  logic       busy,
  input  logic       done,
  input  logic       fail_prog,
  input  logic       fail_erase,
  input  logic       fail_lock,
  output logic       start_prog,
  output logic       start_erase,
  output logic       show_status,
  output logic [7:0] sr
);
  cui_st_t st_q, st_d;
  logic    smode_q, smode_d;
  logic    e_er_q, e_er_d, e_pg_q, e_pg_d, e_lk_q, e_lk_d;
  logic    accept;

  always_comb begin
    st_d        = st_q;
    smode_d     = smode_q;
    e_er_d      = e_er_q;
    e_pg_d      = e_pg_q;
    e_lk_d      = e_lk_q;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    accept      = we && rp_n && !busy;
    case (st_q)
      CS_IDLE: if (accept) begin
        case (cmd)
          CMD_READ:  smode_d = 1'b0;
          CMD_STAT:  smode_d = 1'b1;
          CMD_CLR:   begin e_er_d = 1'b0; e_pg_d = 1'b0; e_lk_d = 1'b0; end
          CMD_PROG:  st_d = CS_PROG;
          CMD_ERASE: st_d = CS_ERASE;
          default:   ;
        endcase
      end
      CS_PROG: if (accept) begin
        start_prog = 1'b1;
        st_d       = CS_IDLE;
        smode_d    = 1'b1;
      end
      CS_ERASE: if (accept) begin
        st_d    = CS_IDLE;
        smode_d = 1'b1;
        if (cmd == CMD_CONF) begin
          start_erase = 1'b1;
        end else begin
          e_er_d = 1'b1;
          e_pg_d = 1'b1;
        end
      end
      default: st_d = CS_IDLE;
    endcase
    if (done) begin
      e_er_d = e_er_d | fail_erase;
      e_pg_d = e_pg_d | fail_prog;
      e_lk_d = e_lk_d | fail_lock;
    end
    if (!rp_n) begin
      st_d        = CS_IDLE;
      smode_d     = 1'b0;
      e_er_d      = 1'b0;
      e_pg_d      = 1'b0;
      e_lk_d      = 1'b0;
      start_prog  = 1'b0;
      start_erase = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CS_IDLE;
      smode_q <= 1'b0;
      e_er_q  <= 1'b0;
      e_pg_q  <= 1'b0;
      e_lk_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      smode_q <= smode_d;
      e_er_q  <= e_er_d;
      e_pg_q  <= e_pg_d;
      e_lk_q  <= e_lk_d;
    end
  end

  always_comb begin
    show_status = smode_q;
    sr          = {~busy, 1'b0, e_er_q, e_pg_q, 2'b00, e_lk_q, 1'b0};
  end
endmodule

// File: rtl/bbf_flash.sv
module bbf_flash
  import bbf_pkg::*;
#(
  parameter int UNIT_BYTES = 16,
  parameter int PROG_CYC   = 6,
  parameter int ERASE_CYC  = 20,
  parameter bit BOOT_TOP   = 1'b0,
  localparam int UNIT_LG   = $clog2(UNIT_BYTES),
  localparam int AW        = UNIT_LG + UNIT_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rp_n,
  input  logic          wp_n,
  input  logic          byte_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   din,
  output logic [15:0]   dout
);
  logic [1:0]          rst_pipe;
  logic                rst_s;
  logic                go_prog, go_erase, busy, done;
  logic                f_prog, f_erase, f_lock;
  logic                cm_prog, cm_erase, op_byte, show_status;
  logic [AW-1:0]       op_addr;
  logic [15:0]         cm_data;
  logic [2:0]          cm_blk;
  logic [7:0]          sr;
  logic [1:0][AW-1:0]  rd_addr;
  logic [1:0]          rd_byte;
  logic [1:0][15:0]    rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  bbf_cui u_cui (
    .clk(clk), .rst_n(rst_s), .rp_n(rp_n), .we(we), .cmd(din[7:0]),
    .busy(busy), .done(done), .fail_prog(f_prog), .fail_erase(f_erase),
    .fail_lock(f_lock), .start_prog(go_prog), .start_erase(go_erase),
    .show_status(show_status), .sr(sr)
  );

  bbf_wsm #(.AW(AW), .BOOT_TOP(BOOT_TOP), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_wsm (
    .clk(clk), .rst_n(rst_s), .rp_n(rp_n), .wp_n(wp_n),
    .start_prog(go_prog), .start_erase(go_erase), .req_addr(addr),
    .req_data(din), .req_byte(~byte_n), .old_data(rd_data[1]),
    .busy(busy), .op_addr(op_addr), .op_byte(op_byte),
    .commit_data(cm_data), .commit_blk(cm_blk), .commit_prog(cm_prog),
    .commit_erase(cm_erase), .done(done), .fail_prog(f_prog),
    .fail_erase(f_erase), .fail_lock(f_lock)
  );

  always_comb begin
    rd_addr[0] = addr;
    rd_byte[0] = ~byte_n;
    rd_addr[1] = op_addr;
    rd_byte[1] = op_byte;
  end

  bbf_array #(.AW(AW), .BOOT_TOP(BOOT_TOP)) u_arr (
    .clk(clk), .wr_en(cm_prog), .wr_addr(op_addr), .wr_byte(op_byte),
    .wr_data(cm_data), .er_en(cm_erase), .er_blk(cm_blk),
    .rd_addr(rd_addr), .rd_byte(rd_byte), .rd_data(rd_data)
  );

  always_comb begin
    if (!rp_n)                    dout = 16'h0000;
    else if (busy || show_status) dout = {8'h00, sr};
    else                          dout = rd_data[0];
  end
endmodule

// File: rtl/bbf_flash_chk.sv
module bbf_flash_chk #(
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 20
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rp_n,
  input logic        wp_n,
  input logic        we,
  input logic [15:0] din,
  input logic [15:0] dout,
  input logic [7:0]  sr,
  input logic        busy,
  input logic        cm_prog,
  input logic        cm_erase,
  input logic [2:0]  cm_blk,
  input logic        go_erase
);
  logic [15:0] blen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    blen <= '0;
    else if (busy) blen <= blen + 1'b1;
    else           blen <= '0;
  end

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(rp_n)) |-> (blen == 16'(PROG_CYC) || blen == 16'(ERASE_CYC)));

  p_confirm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go_erase |-> (din[7:0] == 8'hD0));

  p_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cm_prog || cm_erase) && cm_blk == 3'd0) |-> wp_n);

  p_busy_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rp_n) |-> (dout[7] == 1'b0 && dout[15:8] == 8'h00));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_n && !we && (sr[4] || sr[5])) |=> (sr[4] || sr[5]));

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_n |=> !busy);

  p_pd_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_n |-> (dout == 16'h0000));
endmodule

bind bbf_flash bbf_flash_chk #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_s), .rp_n(rp_n), .wp_n(wp_n), .we(we), .din(din),
  .dout(dout), .sr(sr), .busy(busy), .cm_prog(cm_prog), .cm_erase(cm_erase),
  .cm_blk(cm_blk), .go_erase(go_erase)
);

// File: tb/sim_bbf_flash.sv
`timescale 1ns/1ps
module sim_bbf_flash;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_CYC   = 6;
  localparam int ERASE_CYC  = 20;
  localparam int AW         = 9;

  logic          clk = 1'b0;
  logic          rst_n, rp_n, wp_n, byte_n, we;
  logic [AW-1:0] addr;
  logic [15:0]   din;
  logic [15:0]   dout;
  int            checks = 0;
  int            failures = 0;
  bit            finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bbf_flash #(.UNIT_BYTES(16), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .BOOT_TOP(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .wp_n(wp_n), .byte_n(byte_n),
    .we(we), .addr(addr), .din(din), .dout(dout)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input logic bn);
    @(negedge clk);
    addr = a; din = d; byte_n = bn; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic bn, input logic [15:0] exp, input string tag);
    @(negedge clk);
    addr = a; byte_n = bn;
    #1;
    chk(tag, dout, exp);
  endtask

  // Counts falling edges with ready low; exp < 0 skips the count check
  task automatic wait_ready(input int exp, input string tag);
    int n = 0;
    #1;
    while (dout[7] == 1'b0 && n < 1000) begin
      n++;
      @(negedge clk);
      #1;
    end
    if (exp >= 0) chk(tag, 16'(n), 16'(exp));
  endtask

  task automatic do_erase(input logic [AW-1:0] a, input string tag);
    wr(a, 16'h0020, 1'b1);
    wr(a, 16'h00D0, 1'b1);
    wait_ready(ERASE_CYC, tag);
  endtask

  task automatic do_prog(input logic [AW-1:0] a, input logic [15:0] d, input logic bn, input string tag);
    wr(a, 16'h0040, 1'b1);
    wr(a, d, bn);
    wait_ready(PROG_CYC, tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    wr(0, 16'h0070, 1'b1);
    rd(0, 1'b1, 16'h0080, "R1 status after reset");
    wr(0, 16'h00FF, 1'b1);
  endtask

  task automatic t_erase;
    do_erase(48, "R4 erase busy length");
    rd(48, 1'b1, 16'h0080, "R12 status shown after erase");
    wr(0, 16'h00FF, 1'b1);
    rd(48, 1'b1, 16'hFFFF, "R4 erased first word");
    rd(63, 1'b0, 16'h00FF, "R4 erased last byte");
  endtask

  task automatic t_prog;
    do_prog(48, 16'h1234, 1'b1, "R2 program busy length");
    rd(48, 1'b1, 16'h0080, "R2 status ok after word program");
    wr(0, 16'h00FF, 1'b1);
    rd(48, 1'b1, 16'h1234, "R2 word stored");
    rd(48, 1'b0, 16'h0034, "R11 even byte read");
    rd(49, 1'b0, 16'h0012, "R11 odd byte read");
    do_prog(50, 16'h00A5, 1'b0, "R2 byte program busy length");
    wr(0, 16'h00FF, 1'b1);
    rd(50, 1'b0, 16'h00A5, "R2 byte stored");
    rd(50, 1'b1, 16'hFFA5, "R2 neighbour byte untouched");
  endtask

  task automatic t_map;
    do_erase(32, "R7 erase first parameter block");
    wr(0, 16'h00FF, 1'b1);
    rd(32, 1'b0, 16'h00FF, "R7 param block start erased");
    rd(47, 1'b0, 16'h00FF, "R7 param block end erased");
    rd(48, 1'b1, 16'h1234, "R7 next block unchanged");
  endtask

  task automatic t_perr;
    do_prog(48, 16'h00FF, 1'b1, "R3 program busy length");
    rd(48, 1'b1, 16'h0090, "R3 program error flagged");
    wr(0, 16'h00FF, 1'b1);
    rd(48, 1'b1, 16'h0034, "R3 stored old AND new");
    wr(0, 16'h0070, 1'b1);
    rd(0, 1'b1, 16'h0090, "R9 error sticky across commands");
    wr(0, 16'h0050, 1'b1);
    rd(0, 1'b1, 16'h0080, "R9 clear status");
    wr(0, 16'h00FF, 1'b1);
  endtask

  task automatic t_seq;
    wr(48, 16'h0020, 1'b1);
    wr(48, 16'h0055, 1'b1);
    #1;
    chk("R5 sequence error status", dout, 16'h00B0);
    wr(0, 16'h00FF, 1'b1);
    rd(48, 1'b1, 16'h0034, "R5 array unchanged");
    wr(0, 16'h0050, 1'b1);
  endtask

  task automatic t_lock;
    wp_n = 1'b1;
    do_erase(0, "R6 boot erase allowed");
    do_prog(2, 16'h5AA5, 1'b1, "R6 boot program allowed");
    rd(2, 1'b1, 16'h0080, "R6 unlocked status");
    wp_n = 1'b0;
    do_prog(0, 16'h0000, 1'b1, "R6 locked program busy length");
    rd(0, 1'b1, 16'h0092, "R6 locked program status");
    wr(0, 16'h00FF, 1'b1);
    rd(0, 1'b1, 16'hFFFF, "R6 locked program no change");
    wr(0, 16'h0050, 1'b1);
    do_erase(0, "R6 locked erase busy length");
    rd(0, 1'b1, 16'h00A2, "R6 locked erase status");
    wr(0, 16'h00FF, 1'b1);
    rd(2, 1'b1, 16'h5AA5, "R6 locked erase no change");
    wr(0, 16'h0050, 1'b1);
    do_prog(32, 16'h1111, 1'b1, "R6 non-boot program");
    rd(32, 1'b1, 16'h0080, "R6 non-boot unaffected by wp_n");
    wr(0, 16'h00FF, 1'b1);
    wp_n = 1'b1;
  endtask

  task automatic t_busy;
    do_erase(256, "R4 erase large block");
    do_prog(256, 16'h003C, 1'b0, "R7 program large block byte");
    wr(64, 16'h0020, 1'b1);
    wr(64, 16'h00D0, 1'b1);
    wr(0, 16'h00FF, 1'b1);
    rd(64, 1'b1, 16'h0000, "R8 status while busy");
    wr(64, 16'h0040, 1'b1);
    wait_ready(-1, "R8 wait");
    rd(64, 1'b1, 16'h0080, "R8 read command ignored while busy");
    wr(0, 16'h00FF, 1'b1);
    rd(64, 1'b1, 16'hFFFF, "R8 program command ignored while busy");
    rd(255, 1'b0, 16'h00FF, "R7 small main block end erased");
    rd(256, 1'b0, 16'h003C, "R7 large main block untouched");
  endtask

  task automatic t_rp;
    wr(48, 16'h0020, 1'b1);
    wr(48, 16'h0011, 1'b1);
    wr(48, 16'h0020, 1'b1);
    wr(48, 16'h00D0, 1'b1);
    repeat (3) @(negedge clk);
    rp_n = 1'b0;
    #1;
    chk("R10 output blank in power-down", dout, 16'h0000);
    wr(48, 16'h0040, 1'b1);
    repeat (2) @(negedge clk);
    rp_n = 1'b1;
    rd(48, 1'b1, 16'h0034, "R10 erase aborted, read-array mode");
    wr(0, 16'h0070, 1'b1);
    rd(0, 1'b1, 16'h0080, "R10 status cleared, write ignored");
    wr(0, 16'h00FF, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; rp_n = 1'b1; wp_n = 1'b1; byte_n = 1'b1;
    we = 1'b0; addr = '0; din = '0;
    t_reset;
    t_erase;
    t_prog;
    t_map;
    t_perr;
    t_seq;
    t_lock;
    t_busy;
    t_rp;
    do_erase(32, "R1 setup");
    wr(0, 16'h00FF, 1'b1);
    t_reset;
    rd(32, 1'b1, 16'hFFFF, "R1 read-array mode and array kept across reset");
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule